// File: doc/BRIEF.md
# Operand Bus Cycle Sequencer

This block is a bus master that runs one operand transfer on a shared 16-bit bus once it holds the bus. A client offers a transfer as a kind code, an address and write data. The block raises a bus request and waits until the bus grant is present and no other master signals bus busy. It then takes the transfer and sequences it on the bus. When the transfer is over it returns a one-cycle completion pulse, an error flag and any read data.

All timing is counted in half bus clocks. The block runs on a core clock at twice the bus rate and produces the bus clock itself as a phase bit, so every register stays on one clock. A transfer has five stages:

- IDLE: no transfer is active.
- ADDR: one half clock. Grant acknowledge, the state indicator and the address-side outputs go valid.
- LEAD: one half clock with the strobe still high.
- WAIT: the strobe is low. Acknowledge and error are sampled at each rising bus edge, and any bus clock without either adds a wait state.
- TERM: one half clock after detection, after which the strobe and the state indicator return high and low.

The transitions are IDLE to ADDR on acceptance, ADDR to LEAD, LEAD to WAIT, WAIT to TERM on a rising-edge hit, and TERM to IDLE.

Top module: `opbus_cycle_ctrl`

## Requirements
- R1: After reset the block is idle: strobe_n_o=1, state_o=0, grant_ack_o=0, data_oe_o=0, rsp_done=0 and bus_clk_o=0, and bus_req_o=0 while req_valid=0.
- R2: While idle, bus_req_o follows req_valid. It stays 1 for the whole of a transfer.
- R3: A transfer is accepted only when req_ready=1 and req_valid=1. req_ready=1 only when the block is idle, bus_grant_i=1, bus_busy_i=0 and bus_clk_o=0. While grant is missing or busy is set, no transfer starts.
- R4: In the core cycle after acceptance (the address stage, with bus_clk_o=1), grant_ack_o=1 and state_o=1, and the address-side outputs are valid together. These are addr_o=req_addr, mio_o = NOT req_kind[1] (req_kind[1]=1 selects I/O, mio_o=1 means memory) and rd_wr_o = NOT req_kind[0] (req_kind[0]=1 is a write, rd_wr_o=1 means read).
- R5: strobe_n_o stays 1 through the address stage and the following half clock. It goes low exactly two core cycles (one bus clock) after the address stage begins.
- R6: Acknowledge (xfer_ack_n_i low) is sampled only at rising bus edges (core cycles with bus_clk_o=0) while the strobe is low. A low level during a bus_clk_o=1 half is ignored. Each unanswered bus clock adds two core cycles, so with w wait states the strobe stays low for 3+2w core cycles.
- R7: The transfer ends one half clock after the detecting edge. In the next core cycle strobe_n_o=1, state_o=0 and rsp_done=1 for exactly one cycle.
- R8: On a read, rsp_rdata equals bus_data_i as it stood in the final half clock of the transfer. It is presented with rsp_done.
- R9: On a write, data_oe_o=1 and data_o=req_wdata from the half clock after the address stage until termination. On a read, data_oe_o stays 0.
- R10: bus_err_n_i low at a sampling edge ends the transfer with the same timing as acknowledge and sets rsp_err=1 with rsp_done. When both are low, the error wins.
- R11: At termination, bus_req_o and grant_ack_o fall unless req_valid=1 at that point, in which case both stay 1 and a back-to-back transfer can be accepted in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a transfer |
| req_kind | input | 2 | Bit 1: I/O select, bit 0: write |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Transfer can be taken this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion came through the error input |
| rsp_rdata | output | 16 | Captured read data |
| bus_req_o | output | 1 | Bus request |
| bus_grant_i | input | 1 | Bus grant |
| bus_busy_i | input | 1 | Another master holds the bus |
| grant_ack_o | output | 1 | Grant acknowledge |
| bus_clk_o | output | 1 | Generated bus clock phase |
| state_o | output | 1 | Transfer-in-progress indicator |
| mio_o | output | 1 | 1 memory, 0 I/O |
| rd_wr_o | output | 1 | 1 read, 0 write |
| addr_o | output | 16 | Bus address |
| strobe_n_o | output | 1 | Active-low data strobe |
| data_o | output | 16 | Write data to bus |
| data_oe_o | output | 1 | Write data drive enable |
| bus_data_i | input | 16 | Read data from bus |
| xfer_ack_n_i | input | 1 | Active-low transfer acknowledge |
| bus_err_n_i | input | 1 | Active-low bus error |

## Verification
The assertions rely on two conditions for a transfer: grant is not withdrawn while the transfer runs, and acknowledge and error are settled levels at every rising core edge. The block does not watch grant after acceptance and samples acknowledge and error directly. The stimulus therefore holds grant high and busy low from acceptance to completion, and changes every input at the falling core edge. Deliberately misplaced acknowledge pulses are confined to the bus-clock-high halves, where the sequencer must ignore them.

// File: rtl/opbus_pkg.sv
package opbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_LEAD = 3'd2,
        ST_WAIT = 3'd3,
        ST_TERM = 3'd4
    } opbus_state_e;

    typedef struct packed {
        logic is_io;
        logic is_write;
    } opbus_kind_t;

endpackage

// File: rtl/opbus_phase.sv
module opbus_phase (
    input  logic clk,
    input  logic rst_n,
    output logic ph_hi
);
    // ph_hi = 1 marks the high half of the bus clock; the edge leaving a
    // low half is the rising bus edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_hi <= 1'b0;
        else        ph_hi <= ~ph_hi;
    end

    a_r6_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ph_hi != $past(ph_hi)));
endmodule

// File: rtl/opbus_seq.sv
module opbus_seq
    import opbus_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ph_hi,
    input  logic         req_valid,
    input  logic         bus_grant_i,
    input  logic         bus_busy_i,
    input  logic         xfer_ack_n_i,
    input  logic         bus_err_n_i,
    output opbus_state_e st,
    output logic         accept,
    output logic         req_ready,
    output logic         bus_req_o,
    output logic         grant_ack_o,
    output logic         state_o,
    output logic         strobe_n_o,
    output logic         rsp_done,
    output logic         rsp_err
);
    opbus_state_e nxt;
    logic         hit;
    logic         err_lat;
    logic         keep_r;
    logic         active;

    // Rising bus edge falls at the end of a low half.
    assign hit = ~ph_hi & (~xfer_ack_n_i | ~bus_err_n_i);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next-state logic.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (accept) nxt = ST_ADDR;
            ST_ADDR: nxt = ST_LEAD;
            ST_LEAD: nxt = ST_WAIT;
            ST_WAIT: if (hit) nxt = ST_TERM;
            ST_TERM: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        active      = (st != ST_IDLE);
        req_ready   = (st == ST_IDLE) & bus_grant_i & ~bus_busy_i & ~ph_hi;
        accept      = req_ready & req_valid;
        bus_req_o   = active | req_valid;
        grant_ack_o = active | keep_r;
        state_o     = active;
        strobe_n_o  = ~((st == ST_WAIT) | (st == ST_TERM));
    end

    // Completion status and grant hold-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_lat  <= 1'b0;
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            keep_r   <= 1'b0;
        end else begin
            if (st == ST_WAIT && hit) err_lat <= ~bus_err_n_i;
            rsp_done <= (st == ST_TERM);
            rsp_err  <= (st == ST_TERM) & err_lat;
            if (st == ST_TERM)      keep_r <= req_valid;
            else if (st != ST_IDLE) keep_r <= 1'b0;
            else if (!req_valid)    keep_r <= 1'b0;
        end
    end

    a_r3_accept_on_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR) |-> (ph_hi && $past(st) == ST_IDLE));
    a_r4_addr_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st == ST_ADDR));
    a_r5_lead_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR) |=> (st == ST_LEAD) ##1 (st == ST_WAIT));
    a_r6_exit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TERM) |-> ($past(st) == ST_WAIT && !$past(ph_hi)));
    a_r7_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);
endmodule

// File: rtl/opbus_dpath.sv
module opbus_dpath
    import opbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  opbus_state_e      st,
    input  logic              accept,
    input  opbus_kind_t       kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              mio_o,
    output logic              rd_wr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam logic [ADDR_W-1:0] ADDR_IDLE = '0;

    opbus_kind_t       kind_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] wdata_r;
    logic              active;
    logic              drive_win;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_r    <= '0;
            addr_r    <= '0;
            wdata_r   <= '0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                kind_r  <= kind_i;
                addr_r  <= addr_i;
                wdata_r <= wdata_i;
            end
            if (st == ST_TERM && !kind_r.is_write) rsp_rdata <= bus_data_i;
        end
    end

    always_comb begin
        active    = (st != ST_IDLE);
        drive_win = (st == ST_LEAD) | (st == ST_WAIT) | (st == ST_TERM);
        addr_o    = active ? addr_r : ADDR_IDLE;
        mio_o     = active & ~kind_r.is_io;
        rd_wr_o   = ~(active & kind_r.is_write);
        data_oe_o = drive_win & kind_r.is_write;
        data_o    = data_oe_o ? wdata_r : '0;
    end

    a_r9_drive_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !rd_wr_o);
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(addr_o) && $stable(rd_wr_o));
endmodule

// File: rtl/opbus_cycle_ctrl.sv
module opbus_cycle_ctrl
    import opbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req_o,
    input  logic              bus_grant_i,
    input  logic              bus_busy_i,
    output logic              grant_ack_o,
    output logic              bus_clk_o,
    output logic              state_o,
    output logic              mio_o,
    output logic              rd_wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              strobe_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              xfer_ack_n_i,
    input  logic              bus_err_n_i
);
    logic         ph_hi;
    logic         accept;
    opbus_state_e st;
    opbus_kind_t  kind;

    assign kind      = opbus_kind_t'(req_kind);
    assign bus_clk_o = ph_hi;

    opbus_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_hi (ph_hi)
    );

    opbus_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ph_hi        (ph_hi),
        .req_valid    (req_valid),
        .bus_grant_i  (bus_grant_i),
        .bus_busy_i   (bus_busy_i),
        .xfer_ack_n_i (xfer_ack_n_i),
        .bus_err_n_i  (bus_err_n_i),
        .st           (st),
        .accept       (accept),
        .req_ready    (req_ready),
        .bus_req_o    (bus_req_o),
        .grant_ack_o  (grant_ack_o),
        .state_o      (state_o),
        .strobe_n_o   (strobe_n_o),
        .rsp_done     (rsp_done),
        .rsp_err      (rsp_err)
    );

    opbus_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .st         (st),
        .accept     (accept),
        .kind_i     (kind),
        .addr_i     (req_addr),
        .wdata_i    (req_wdata),
        .bus_data_i (bus_data_i),
        .addr_o     (addr_o),
        .mio_o      (mio_o),
        .rd_wr_o    (rd_wr_o),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .rsp_rdata  (rsp_rdata)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !state_o |-> (strobe_n_o && !data_oe_o));
    a_r7_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (strobe_n_o && !$past(strobe_n_o)));
    a_r11_req_covers_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        state_o |-> (bus_req_o && grant_ack_o));
endmodule

// File: tb/test_opbus_cycle_ctrl.sv
module test_opbus_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_req_o, grant_ack_o, bus_clk_o, state_o, mio_o, rd_wr_o;
    logic        bus_grant_i = 1'b1;
    logic        bus_busy_i = 1'b0;
    logic [15:0] addr_o, data_o;
    logic        strobe_n_o, data_oe_o;
    logic [15:0] bus_data_i = '0;
    logic        xfer_ack_n_i = 1'b1;
    logic        bus_err_n_i = 1'b1;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    opbus_cycle_ctrl i_opbus_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_req_o(bus_req_o), .bus_grant_i(bus_grant_i), .bus_busy_i(bus_busy_i),
        .grant_ack_o(grant_ack_o), .bus_clk_o(bus_clk_o), .state_o(state_o),
        .mio_o(mio_o), .rd_wr_o(rd_wr_o), .addr_o(addr_o), .strobe_n_o(strobe_n_o),
        .data_o(data_o), .data_oe_o(data_oe_o), .bus_data_i(bus_data_i),
        .xfer_ack_n_i(xfer_ack_n_i), .bus_err_n_i(bus_err_n_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // term: 0 = acknowledge, 1 = error, 2 = both
    task automatic run_op(input logic [1:0] kind, input logic [15:0] a, input logic [15:0] wd,
                          input logic [15:0] rd, input int waits, input int term, input bit chain);
        int guard = 0;
        req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd;
        bus_data_i = ~rd;
        #1;
        while (!req_ready && guard < 8) begin
            @(negedge clk); #1; guard++;
        end
        chk("R3 ready only on low bus half", {31'd0, bus_clk_o}, 32'd0);
        @(negedge clk); #1;  // address stage
        if (!chain) req_valid = 1'b0;
        chk("R4 bus clock high at address stage", {31'd0, bus_clk_o}, 32'd1);
        chk("R4 state indicator", {31'd0, state_o}, 32'd1);
        chk("R4 grant acknowledge", {31'd0, grant_ack_o}, 32'd1);
        chk("R4 address", {16'd0, addr_o}, {16'd0, a});
        chk("R4 memory/io select", {31'd0, mio_o}, {31'd0, ~kind[1]});
        chk("R4 read/write", {31'd0, rd_wr_o}, {31'd0, ~kind[0]});
        chk("R5 strobe high in address stage", {31'd0, strobe_n_o}, 32'd1);
        chk("R2 request held", {31'd0, bus_req_o}, 32'd1);
        @(negedge clk); #1;  // lead half
        chk("R5 strobe high in lead half", {31'd0, strobe_n_o}, 32'd1);
        chk("R9 drive enable from lead half", {31'd0, data_oe_o}, {31'd0, kind[0]});
        if (kind[0]) chk("R9 write data", {16'd0, data_o}, {16'd0, wd});
        for (int k = 0; k <= waits; k++) begin
            @(negedge clk); #1;  // bus clock high half
            chk(k == 0 ? "R5 strobe low after one bus clock" : "R6 strobe low in wait",
                {31'd0, strobe_n_o}, 32'd0);
            xfer_ack_n_i = 1'b0;  // misplaced, must be ignored (R6)
            @(negedge clk); #1;  // low half, sampled at next edge
            chk("R6 still waiting", {31'd0, state_o & ~strobe_n_o}, 32'd1);
            xfer_ack_n_i = 1'b1;
            bus_err_n_i  = 1'b1;
            if (k == waits) begin
                if (term != 1) xfer_ack_n_i = 1'b0;
                if (term != 0) bus_err_n_i  = 1'b0;
            end
        end
        @(negedge clk); #1;  // termination half
        xfer_ack_n_i = 1'b1; bus_err_n_i = 1'b1;
        bus_data_i = rd;
        chk("R7 strobe low for half clock after detection", {31'd0, strobe_n_o}, 32'd0);
        chk("R7 no done before release", {31'd0, rsp_done}, 32'd0);
        chk("R9 drive through termination", {31'd0, data_oe_o}, {31'd0, kind[0]});
        @(negedge clk); #1;
        bus_data_i = ~rd;
        chk("R7 done pulse", {31'd0, rsp_done}, 32'd1);
        chk("R7 strobe released", {31'd0, strobe_n_o}, 32'd1);
        chk("R7 state indicator low", {31'd0, state_o}, 32'd0);
        chk("R10 error flag", {31'd0, rsp_err}, {31'd0, term != 0});
        if (!kind[0]) chk("R8 read data", {16'd0, rsp_rdata}, {16'd0, rd});
        chk("R9 drive released", {31'd0, data_oe_o}, 32'd0);
        chk("R11 request after termination", {31'd0, bus_req_o}, {31'd0, chain});
        chk("R11 grant acknowledge after termination", {31'd0, grant_ack_o}, {31'd0, chain});
        if (chain) chk("R11 back-to-back ready", {31'd0, req_ready}, 32'd1);
        else begin
            @(negedge clk); #1;
            chk("R7 done lasts one cycle", {31'd0, rsp_done}, 32'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 strobe", {31'd0, strobe_n_o}, 32'd1);
        chk("R1 state", {31'd0, state_o}, 32'd0);
        chk("R1 grant ack", {31'd0, grant_ack_o}, 32'd0);
        chk("R1 request", {31'd0, bus_req_o}, 32'd0);
        chk("R1 done", {31'd0, rsp_done}, 32'd0);
        chk("R1 drive", {31'd0, data_oe_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 bus clock low after reset", {31'd0, bus_clk_o}, 32'd0);

        // R3: busy blocks acceptance, then missing grant blocks it.
        bus_busy_i = 1'b1; req_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            chk("R3 busy blocks ready", {31'd0, req_ready}, 32'd0);
            chk("R3 busy keeps idle", {31'd0, state_o}, 32'd0);
            chk("R2 request follows valid", {31'd0, bus_req_o}, 32'd1);
        end
        bus_busy_i = 1'b0; bus_grant_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            chk("R3 no grant blocks ready", {31'd0, req_ready}, 32'd0);
            chk("R3 no grant keeps idle", {31'd0, state_o}, 32'd0);
        end
        req_valid = 1'b0; #1;
        chk("R2 request drops with valid", {31'd0, bus_req_o}, 32'd0);
        bus_grant_i = 1'b1;
        @(negedge clk); #1;

        for (int kd = 0; kd < 4; kd++)
            for (int w = 0; w < 4; w++)
                for (int t = 0; t < 3; t++) begin
                    logic [15:0] a;
                    a = 16'h1000 * kd[15:0] + 16'h0111 * w[15:0] + t[15:0];
                    run_op(kd[1:0], a, a ^ 16'hA5A5, ~a + 16'h0003, w, t, 1'b0);
                end

        // R11: chained transfers keep the bus.
        run_op(2'b00, 16'h4321, 16'h0, 16'h5A5A, 1, 0, 1'b1);
        run_op(2'b01, 16'h8765, 16'h1357, 16'h0, 0, 0, 1'b1);
        run_op(2'b10, 16'hFFFF, 16'h0, 16'h00FF, 2, 1, 1'b0);

        summary();
        $finish;
    end
endmodule